// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the host side of an asynchronous byte-wide EPROM that has 16 address lines. The host issues a read on a valid/ready request channel. The controller then drives the address, the active-low chip-select and the active-low output-gate pins. It counts clock cycles to cover the device's access, gate and float times. After that it registers the byte it sampled and returns it with a one-cycle done pulse.

Chip-select acts as the power and selection control, and output-gate acts as the bus control. Output-gate is asserted late, so that it has been low for exactly its own, shorter, access time when the byte is sampled. After output-gate is released, the block waits out the float time before it accepts the next request, so that no other device can be enabled onto the bus too early. If no request arrives for a number of cycles set by a parameter, the block drops chip-select and the device goes into standby. The next request selects the device again, and that access pays the full select-to-data time. All cycle counts are derived from nanosecond parameters and the clock period.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: Out of reset, `memCeN` and `memOeN` are 1 (device in standby), `reqReady` is 1 and `rspValid` is 0.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. After that edge, `memAddr` equals the accepted address, `memCeN` is 0 and `reqReady` is 0.
- R3: From the accept until the done pulse, `memAddr` holds the accepted address and `memCeN` stays 0.
- R4: Let WAIT = max(ceil(T_ACC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)), where every count is at least 1. `rspValid` is high for exactly one cycle, after the WAIT-th rising edge following the accept. `rspData` then holds the byte present on `memData` at that edge.
- R5: `memOeN` goes low after rising edge WAIT-OE (OE = ceil(T_OE_NS/CLK_NS)) following the accept, and goes high again at the capture edge. It is therefore low for exactly OE cycles before the sample.
- R6: After the capture edge, `reqReady` rises only after FLT = ceil(T_FLOAT_NS/CLK_NS) further rising edges. `memOeN` stays 1 for that whole time.
- R7: `memOeN` is never 0 while `memCeN` is 1.
- R8: After IDLE_CYC consecutive ready cycles with the device selected and no request, `memCeN` rises to 1. A later request drives it low again at the accept.
- R9: `reqValid` and `reqAddr` are ignored while `reqReady` is 0. They do not change `memAddr` and do not produce an extra `rspValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqAddr | input | 16 | Byte address of the request |
| rspValid | output | 1 | One-cycle done pulse |
| rspData | output | 8 | Byte read, valid with rspValid |
| memAddr | output | 16 | Address pins of the EPROM |
| memCeN | output | 1 | Chip select, active low (standby when high) |
| memOeN | output | 1 | Output gate, active low |
| memData | input | 8 | Data pins of the EPROM |

## Verification
The bench runs reads against a timed memory model. The model returns the inverted byte whenever the address, select or gate time has not yet elapsed, so any shortened wait or any early or late gate shows up as wrong data. Directed reads cover three cases: the first access from reset standby, back-to-back reads that keep the device selected, and a read after an idle period long enough to force standby, which tells the timeout path apart from the selected-idle path. Random reads mix random addresses and random idle gaps on both sides of the timeout. Some of them keep `reqValid` high with a different address while busy, which separates correctly ignored requests from address corruption or a second response.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_FLOAT  = 2'd3
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch address, select device
    logic sleep;    // deselect device (standby)
    logic oeLow;    // open output gate
    logic capture;  // sample data, close gate, pulse done
  } rdStrobe_t;

  // ceil(timeNs / periodNs), never below one cycle
  function automatic int cyclesFor(input int timeNs, input int periodNs);
    int c;
    c = (timeNs + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/eprom_rd_ctl.sv
module eprom_rd_ctl
  import eprom_rd_pkg::*;
#(
  parameter int WAIT_CYC = 3,
  parameter int OE_CYC   = 2,
  parameter int FLT_CYC  = 2,
  parameter int IDLE_CYC = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output rdStrobe_t strb
);

  localparam int OE_LEAD = WAIT_CYC - OE_CYC;
  localparam int MAX_A   = (WAIT_CYC > FLT_CYC) ? WAIT_CYC : FLT_CYC;
  localparam int MAX_C   = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] FLT_LAST  = CNT_W'(FLT_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] OE_MARK   = CNT_W'(OE_LEAD);

  rdState_t         state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             oeAtLoad;

  generate
    if (OE_LEAD == 0) begin : g_oe_at_load
      assign oeAtLoad = 1'b1;
    end else begin : g_oe_late
      assign oeAtLoad = 1'b0;
    end
  endgenerate

  assign reqReady = (state == ST_SLEEP) || (state == ST_IDLE);

  always_comb begin
    strb   = '0;
    nState = state;
    nCnt   = cnt;
    case (state)
      ST_SLEEP, ST_IDLE: begin
        if (reqValid) begin
          strb.load  = 1'b1;
          strb.oeLow = oeAtLoad;
          nState     = ST_ACCESS;
          nCnt       = '0;
        end else if (state == ST_IDLE) begin
          if (cnt == IDLE_LAST) begin
            strb.sleep = 1'b1;
            nState     = ST_SLEEP;
            nCnt       = '0;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
      end
      ST_ACCESS: begin
        if (cnt == WAIT_LAST) begin
          strb.capture = 1'b1;
          nState       = ST_FLOAT;
          nCnt         = '0;
        end else begin
          nCnt       = cnt + 1'b1;
          strb.oeLow = (cnt + 1'b1) == OE_MARK;
        end
      end
      default: begin
        if (cnt == FLT_LAST) begin
          nState = ST_IDLE;
          nCnt   = '0;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_SLEEP;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS) |-> (cnt <= WAIT_LAST)); // R4

endmodule

// File: rtl/eprom_rd_dp.sv
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.load) begin
        memAddr <= reqAddr;
        memCeN  <= 1'b0;
      end else if (strb.sleep) begin
        memCeN  <= 1'b1;
      end
      if (strb.capture) begin
        memOeN  <= 1'b1;
        rspData <= memData;
      end else if (strb.oeLow) begin
        memOeN  <= 1'b0;
      end
    end
  end

  AST_GATE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R4

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 20,
  parameter int T_ACC_NS   = 45,
  parameter int T_OE_NS    = 25,
  parameter int T_FLOAT_NS = 25,
  parameter int IDLE_CYC   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  localparam int ACC_CYC  = cyclesFor(T_ACC_NS, CLK_NS);
  localparam int OE_CYC   = cyclesFor(T_OE_NS, CLK_NS);
  localparam int FLT_CYC  = cyclesFor(T_FLOAT_NS, CLK_NS);
  localparam int WAIT_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;

  rdStrobe_t strb;

  eprom_rd_ctl #(
    .WAIT_CYC(WAIT_CYC),
    .OE_CYC  (OE_CYC),
    .FLT_CYC (FLT_CYC),
    .IDLE_CYC(IDLE_CYC)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strb    (strb)
  );

  eprom_rd_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .memData (memData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .rspValid(rspValid),
    .rspData (rspData)
  );

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!memCeN && !reqReady)); // R2
  AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(memAddr)); // R9
  AST_READY_GATE_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memOeN); // R6

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb;

  localparam int CLK_NS = 20;
  localparam int T_ACC  = 45;
  localparam int T_OE   = 25;
  localparam int T_FLT  = 25;
  localparam int IDLE   = 16;

  function automatic int cdiv(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_ACC  = cdiv(T_ACC, CLK_NS);
  localparam int E_OE   = cdiv(T_OE, CLK_NS);
  localparam int E_FLT  = cdiv(T_FLT, CLK_NS);
  localparam int E_WAIT = (E_ACC > E_OE) ? E_ACC : E_OE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [15:0] memAddr;
  logic        memCeN;
  logic        memOeN;
  logic [7:0]  memData = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eprom_rd_ctrl #(
    .CLK_NS(CLK_NS), .T_ACC_NS(T_ACC), .T_OE_NS(T_OE),
    .T_FLOAT_NS(T_FLT), .IDLE_CYC(IDLE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memData(memData)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // timed memory model: wrong (inverted) byte until all delays have elapsed
  realtime tAddr = 0.0, tCe = 0.0, tOe = 0.0;
  always @(memAddr) tAddr = $realtime;
  always @(negedge memCeN) tCe = $realtime;
  always @(negedge memOeN) tOe = $realtime;
  always begin
    #1;
    if (!memCeN && !memOeN && ($realtime - tAddr >= T_ACC) &&
        ($realtime - tCe >= T_ACC) && ($realtime - tOe >= T_OE))
      memData = pat(memAddr);
    else
      memData = ~pat(memAddr);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] a, input bit poke);
    int k, m, oeLow;
    bit addrOk, ceOk, extra, oeShut;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    chk(!memCeN && memAddr == a && !reqReady, "R2 accept", {memCeN, memAddr}, {1'b0, a});
    if (poke) reqAddr = ~a;
    else reqValid = 1'b0;
    k = 0; oeLow = 0; addrOk = 1; ceOk = 1;
    while (!rspValid && k < 100) begin
      if (!memOeN) oeLow++;
      @(negedge clk);
      k++;
      if (memAddr != a) addrOk = 0;
      if (memCeN) ceOk = 0;
    end
    reqValid = 1'b0;
    chk(k == E_WAIT, "R4 latency", k, E_WAIT);
    chk(rspData == pat(a), "R4 data", rspData, pat(a));
    chk(oeLow == E_OE, "R5 gate cycles", oeLow, E_OE);
    chk(memOeN, "R5 gate closed at capture", memOeN, 1);
    chk(addrOk && ceOk, "R3 address/select held", {addrOk, ceOk}, 3);
    m = 0; extra = 0; oeShut = 1;
    while (!reqReady && m < 100) begin
      @(negedge clk);
      m++;
      if (rspValid) extra = 1;
      if (!memOeN) oeShut = 0;
    end
    chk(m == E_FLT && oeShut, "R6 float wait", m, E_FLT);
    chk(m * CLK_NS >= T_FLT, "R6 float time", m * CLK_NS, T_FLT);
    if (poke) chk(!extra && addrOk, "R9 busy request ignored", extra, 0);
    else chk(!extra, "R4 single pulse", extra, 0);
  endtask

  // idle g negedges from a ready point, then check select state
  task automatic idleFor(input int g);
    for (int j = 0; j < g; j++) @(negedge clk);
    chk(memCeN == (g >= IDLE), "R8 standby state", memCeN, (g >= IDLE));
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCeN && memOeN && reqReady && !rspValid, "R1 reset state",
        {memCeN, memOeN, reqReady, rspValid}, 4'b1110);
    chk(!(memCeN && !memOeN), "R7 gate without select", memOeN, 1);

    doRead(16'h1234, 1'b0);   // from reset standby
    doRead(16'hFFFF, 1'b0);   // back to back, stays selected
    doRead(16'h0000, 1'b1);   // busy request poked

    // count cycles from ready to standby
    cnt = 0;
    while (!memCeN && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (!memOeN) chk(1'b0, "R7 gate in idle", 0, 1);
    end
    chk(cnt == IDLE, "R8 timeout", cnt, IDLE);
    chk(memOeN, "R7 standby gate high", memOeN, 1);
    doRead(16'hA5C3, 1'b0);   // wake from standby

    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = $urandom_range(0, 24);
      while (!reqReady) @(negedge clk);
      idleFor(gap);
      doRead(16'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule